// File: doc/BRIEF.md
# Range-Gate Sample Buffer with Command Control

This block collects the receive-window output of a pulsed radar front end and sorts it by range gate. Each packed I/Q word arrives with a gate index. While an acquisition is running and the receive window is open, the word is appended to the buffer owned by that gate. The buffers form banks: the high bits of the gate index pick the bank and the low bits pick the buffer inside it.

A host drives the block with single command words. The two low bits of a word pick the operation and the bits above them are its operand. Four operations exist. The first starts a live acquisition. The second starts an acquisition that stores a counting pattern instead of sample data. The third stops acquisition. The fourth streams one buffer out, and its operand names the bank and the buffer. When the host asks for a stop while a window is open, the block waits for that window to close. If a buffer is full, further writes to it are dropped and a sticky flag is raised for the bank that holds it.

Top module: `rg_acq_buf`

## Requirements
- R1: After reset, acq_o, rd_valid_o and every ovf_o bit are 0, and every buffer is empty.
- R2: A command is taken when cmd_valid_i is high. cmd_i[1:0] picks the operation: 0 = live start, 1 = read, 2 = pattern start, 3 = stop. Start, pattern start and read are obeyed only while idle. Stop is obeyed only while acquiring. Any other command has no effect.
- R3: A live or pattern start raises acq_o on the following cycle, empties every buffer and clears ovf_o.
- R4: While acq_o is high, a sample is appended to buffer smp_gate_i at its next free entry in any cycle where window_i and smp_valid_i are both high. The upper BANK_W bits of the gate index are the bank and the lower BUF_W bits are the buffer. Samples at any other time are dropped.
- R5: In pattern mode, smp_data_i is ignored. The stored word holds the entry position in bits [15:0] and the gate index in bits [16+GATE_W-1:16], with all other bits zero.
- R6: A stop taken while window_i is low drops acq_o on the next cycle. A stop taken while window_i is high keeps acq_o high, and samples are still stored, until a cycle with window_i low. acq_o then drops on the following cycle.
- R7: A sample sent to a buffer that already holds DEPTH entries is dropped, and the ovf_o bit of its bank is set. That bit stays set, through stops and reads, until the next start or pattern start.
- R8: A read command carries the bank in cmd_i[CMD_W-1 -: BANK_W] and the buffer in the BUF_W bits just above bit 1. Counting the clock edge that takes the command as the first, the first entry appears on rd_data_o with rd_valid_o high after the second edge. Entries then follow one per cycle in write order, and rd_last_o marks the final one. An empty buffer yields no beats. Reading leaves the contents in place.
- R9: While a read stream is running, commands are ignored, and acq_o and rd_valid_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | CMD_W | Operation in [1:0], operand above |
| window_i | input | 1 | Receive window open |
| smp_valid_i | input | 1 | Sample strobe |
| smp_gate_i | input | GATE_W | Range-gate index of the sample |
| smp_data_i | input | DATA_W | Packed I/Q sample |
| rd_valid_o | output | 1 | Read beat valid |
| rd_last_o | output | 1 | Final beat of a read stream |
| rd_data_o | output | DATA_W | Read beat data |
| acq_o | output | 1 | Acquisition running |
| ovf_o | output | NUM_BANKS | Sticky overflow flag per bank |

## Verification
The bench uses a configuration of two banks of four buffers, each four entries deep. It fills every gate and reads every gate back, so a design that swapped the bank and buffer fields would return the data of the wrong buffer. The bench issues a stop in the middle of a window and then sends one more sample. A design that stopped at once would lose that sample, and acq_o would fall a cycle too early. The bench overfills one buffer by two samples. A design that wrapped its write pointer would overwrite entry 0, and a design with a shared flag would set the other bank's bit. The bench also checks that the flag survives a stop and a read. Finally, it sends a read during acquisition and a start during a read. A decoder that obeyed either command would produce a spurious stream or a spurious acquisition.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_READ  = 2'd1,
    OP_TEST  = 2'd2,
    OP_STOP  = 2'd3
  } rg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_READ
  } rg_state_e;
endpackage

// File: rtl/rg_cmd_ctrl.sv
module rg_cmd_ctrl
  import rg_pkg::*;
#(
  parameter int GATE_W = 6,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [GATE_W+1:0]   cmd_i,
  input  logic                window_i,
  input  logic [CNT_W-1:0]    rd_cnt_i,
  output logic                acq_o,
  output logic                test_o,
  output logic                clear_o,
  output logic                rd_en_o,
  output logic                rd_last_o,
  output logic [GATE_W-1:0]   rd_sel_o,
  output logic [ADDR_W-1:0]   rd_addr_o
);
  rg_state_e          state_q;
  logic               test_q, stop_pend_q;
  logic [GATE_W-1:0]  sel_q;
  logic [CNT_W-1:0]   ptr_q;
  logic               hit_start, hit_read, hit_test, hit_stop;
  logic [GATE_W-1:0]  operand;

  // decoder: low bits select, high bits carry the operand
  always_comb begin
    hit_start = 1'b0;
    hit_read  = 1'b0;
    hit_test  = 1'b0;
    hit_stop  = 1'b0;
    operand   = cmd_i[GATE_W+1:2];
    if (cmd_valid_i) begin
      case (rg_op_e'(cmd_i[1:0]))
        OP_START: hit_start = 1'b1;
        OP_READ:  hit_read  = 1'b1;
        OP_TEST:  hit_test  = 1'b1;
        default:  hit_stop  = 1'b1;
      endcase
    end
  end

  logic stop_req, is_last;
  assign stop_req = stop_pend_q | hit_stop;
  assign is_last  = (ptr_q == rd_cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      test_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      sel_q       <= '0;
      ptr_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (hit_start || hit_test) begin
            state_q     <= ST_ACQ;
            test_q      <= hit_test;
            stop_pend_q <= 1'b0;
          end else if (hit_read) begin
            state_q <= ST_READ;
            sel_q   <= operand;
            ptr_q   <= '0;
          end
        end
        ST_ACQ: begin
          if (stop_req && !window_i) begin
            state_q     <= ST_IDLE;
            stop_pend_q <= 1'b0;
          end else if (hit_stop) begin
            stop_pend_q <= 1'b1;
          end
        end
        default: begin
          if (rd_cnt_i == '0 || is_last) state_q <= ST_IDLE;
          else                           ptr_q   <= ptr_q + CNT_W'(1);
        end
      endcase
    end
  end

  assign acq_o     = (state_q == ST_ACQ);
  assign test_o    = test_q;
  assign clear_o   = (state_q == ST_IDLE) && (hit_start || hit_test);
  assign rd_en_o   = (state_q == ST_READ) && (rd_cnt_i != '0);
  assign rd_last_o = rd_en_o && is_last;
  assign rd_sel_o  = sel_q;
  assign rd_addr_o = ptr_q[ADDR_W-1:0];
endmodule

// File: rtl/rg_fill_track.sv
module rg_fill_track #(
  parameter int NUM_BANKS = 4,
  parameter int NBUF      = 64,
  parameter int DEPTH     = 32,
  parameter int GATE_W    = 6,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 wr_req_i,
  input  logic [GATE_W-1:0]    wr_gate_i,
  input  logic [GATE_W-1:0]    rd_sel_i,
  output logic                 wr_en_o,
  output logic [CNT_W-1:0]     wr_ptr_o,
  output logic [CNT_W-1:0]     rd_cnt_o,
  output logic [NUM_BANKS-1:0] ovf_o
);
  logic [CNT_W-1:0] cnt_arr [NBUF];
  logic             full;

  assign wr_ptr_o = cnt_arr[wr_gate_i];
  assign rd_cnt_o = cnt_arr[rd_sel_i];
  assign full     = (wr_ptr_o == CNT_W'(DEPTH));
  assign wr_en_o  = wr_req_i && !full;

  for (genvar g = 0; g < NBUF; g++) begin : gen_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        c_q <= '0;
      else if (clear_i)                                   c_q <= '0;
      else if (wr_en_o && wr_gate_i == GATE_W'(g))        c_q <= c_q + CNT_W'(1);
    end
    assign cnt_arr[g] = c_q;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gen_ovf
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   f_q <= 1'b0;
      else if (clear_i) f_q <= 1'b0;
      else if (wr_req_i && full && wr_gate_i[GATE_W-1 -: BANK_W] == BANK_W'(b))
        f_q <= 1'b1;
    end
    assign ovf_o[b] = f_q;
  end
endmodule

// File: rtl/rg_store.sv
module rg_store #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 2048,
  parameter int AW     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic              rlast_i,
  input  logic [AW-1:0]     raddr_i,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rd_data_o <= mem[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_valid_o <= re_i;
      rd_last_o  <= re_i && rlast_i;
    end
  end
endmodule

// File: rtl/rg_acq_buf.sv
module rg_acq_buf #(
  parameter int NUM_BANKS     = 4,
  parameter int BUFS_PER_BANK = 16,
  parameter int DEPTH         = 32,
  parameter int DATA_W        = 64,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BUF_W  = $clog2(BUFS_PER_BANK),
  localparam int GATE_W = BANK_W + BUF_W,
  localparam int CMD_W  = GATE_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic                 window_i,
  input  logic                 smp_valid_i,
  input  logic [GATE_W-1:0]    smp_gate_i,
  input  logic [DATA_W-1:0]    smp_data_i,
  output logic                 rd_valid_o,
  output logic                 rd_last_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 acq_o,
  output logic [NUM_BANKS-1:0] ovf_o
);
  localparam int NBUF   = NUM_BANKS * BUFS_PER_BANK;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int AW     = GATE_W + ADDR_W;

  logic              test, clear, rd_en, rd_last, wr_en;
  logic [GATE_W-1:0] rd_sel;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  wr_ptr, rd_cnt;
  logic [DATA_W-1:0] pat_word, wdata;

  rg_cmd_ctrl #(.GATE_W(GATE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .window_i,
    .rd_cnt_i(rd_cnt), .acq_o, .test_o(test), .clear_o(clear),
    .rd_en_o(rd_en), .rd_last_o(rd_last), .rd_sel_o(rd_sel), .rd_addr_o(rd_addr)
  );

  rg_fill_track #(
    .NUM_BANKS(NUM_BANKS), .NBUF(NBUF), .DEPTH(DEPTH),
    .GATE_W(GATE_W), .BANK_W(BANK_W), .CNT_W(CNT_W)
  ) u_fill (
    .clk_i, .rst_ni, .clear_i(clear),
    .wr_req_i(acq_o && window_i && smp_valid_i),
    .wr_gate_i(smp_gate_i), .rd_sel_i(rd_sel),
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .rd_cnt_o(rd_cnt), .ovf_o
  );

  always_comb begin
    pat_word                 = '0;
    pat_word[15:0]           = 16'(wr_ptr);
    pat_word[16 +: GATE_W]   = smp_gate_i;
    wdata = test ? pat_word : smp_data_i;
  end

  rg_store #(.DATA_W(DATA_W), .WORDS(NBUF * DEPTH), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i({smp_gate_i, wr_ptr[ADDR_W-1:0]}), .wdata_i(wdata),
    .re_i(rd_en), .rlast_i(rd_last), .raddr_i({rd_sel, rd_addr}),
    .rd_valid_o, .rd_last_o, .rd_data_o
  );
endmodule

// File: rtl/rg_acq_buf_chk.sv
module rg_acq_buf_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 window_i,
  input logic                 acq_o,
  input logic                 rd_valid_o,
  input logic                 rd_last_o,
  input logic [NUM_BANKS-1:0] ovf_o
);
  // R9
  excl_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acq_o && rd_valid_o));

  // R6
  stop_at_window_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acq_o) |-> !$past(window_i));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ovf_o) & ~ovf_o) != '0) |-> acq_o);

  // R3
  start_clears_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_o) |-> (ovf_o == '0));

  // R8
  stream_gapless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last_o) |=> rd_valid_o);

  // R8
  last_in_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);
endmodule

bind rg_acq_buf rg_acq_buf_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .window_i(window_i), .acq_o(acq_o),
  .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o), .ovf_o(ovf_o)
);

// File: tb/sim_rg_acq_buf.sv
`timescale 1ns/1ps
module sim_rg_acq_buf;
  localparam int NB = 2, BPB = 4, DEP = 4, DW = 32;
  localparam int NG = NB * BPB;
  localparam int GW = 3, CW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, window = 1'b0, smp_valid = 1'b0;
  logic [CW-1:0] cmd = '0;
  logic [GW-1:0] gate = '0;
  logic [DW-1:0] data = '0;
  logic rd_valid, rd_last, acq;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] ovf;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_d [NG][DEP];
  int exp_n [NG];
  bit m_acq = 0, m_test = 0;

  always #2.5 clk = ~clk;

  rg_acq_buf #(.NUM_BANKS(NB), .BUFS_PER_BANK(BPB), .DEPTH(DEP), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .cmd_i(cmd), .window_i(window),
    .smp_valid_i(smp_valid), .smp_gate_i(gate), .smp_data_i(data),
    .rd_valid_o(rd_valid), .rd_last_o(rd_last), .rd_data_o(rd_data),
    .acq_o(acq), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(logic [1:0] op, logic [GW-1:0] opnd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = {opnd, op}; smp_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic put(int g, logic [DW-1:0] d, bit win, bit vld);
    @(negedge clk);
    window = win; smp_valid = vld; gate = GW'(g); data = d;
    if (m_acq && win && vld && exp_n[g] < DEP) begin
      exp_d[g][exp_n[g]] = m_test ? ((DW'(g) << 16) | DW'(exp_n[g])) : d;
      exp_n[g]++;
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_chk(int g, string req);
    int beats = 0;
    send_cmd(2'd1, GW'(g));
    for (int i = 0; i < DEP + 4; i++) begin
      @(negedge clk);
      if (rd_valid) begin
        if (beats < DEP) chk(req, 64'(rd_data), 64'(exp_d[g][beats]));
        chk(req, 64'(rd_last), 64'(beats == exp_n[g] - 1));
        beats++;
      end
    end
    chk(req, 64'(beats), 64'(exp_n[g]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) exp_n[g] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acq", 64'(acq), 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    chk("R1 ovf", 64'(ovf), 0);
    read_chk(2, "R1 R8 empty read");

    // R2 stop while idle does nothing
    send_cmd(2'd3, '0);
    chk("R2 stop idle", 64'(acq), 0);

    // R3 live start
    send_cmd(2'd0, '0); m_acq = 1; m_test = 0;
    chk("R3 acq", 64'(acq), 1);
    chk("R3 ovf", 64'(ovf), 0);

    // R2 R9 read during acquisition ignored
    send_cmd(2'd1, 3'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 read ignored rd_valid", 64'(rd_valid), 0);
      chk("R2 read ignored acq", 64'(acq), 1);
    end

    // R4 live sweep with dropped samples mixed in
    for (int k = 0; k < 3; k++)
      for (int g = 0; g < NG; g++) begin
        put(g, 32'hA500_0000 | (g << 8) | k, 1, 1);
        if (g == 3) begin
          put(g, 32'hDEAD_0000 | k, 0, 1);
          put(g, 32'hBEEF_0000 | k, 1, 0);
        end
      end
    window = 1'b1;

    // R6 stop mid-window
    send_cmd(2'd3, '0);
    chk("R6 acq held", 64'(acq), 1);
    put(0, 32'h5A5A_0003, 1, 1);
    put(0, 32'h0, 0, 0);
    chk("R6 acq before close", 64'(acq), 1);
    m_acq = 0;
    @(negedge clk);
    chk("R6 acq after close", 64'(acq), 0);

    // R4 R8 read back every gate
    for (int g = 0; g < NG; g++) read_chk(g, "R4 R8 live readback");
    read_chk(0, "R8 reread");

    // R9 start during read ignored
    send_cmd(2'd1, 3'd1);
    send_cmd(2'd0, '0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 start in read", 64'(acq), 0);
    end

    // R5 pattern mode, R7 overflow on gate 5 (bank 1)
    send_cmd(2'd2, '0); m_acq = 1; m_test = 1;
    for (int g = 0; g < NG; g++) exp_n[g] = 0;
    chk("R3 pattern acq", 64'(acq), 1);
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < 2; k++) put(g, 32'hFFFF_FFFF, 1, 1);
    put(5, 32'h1234, 1, 1);
    put(5, 32'h1234, 1, 1);
    quiet();
    chk("R7 not yet full", 64'(ovf), 0);
    put(5, 32'h1234, 1, 1);
    quiet();
    chk("R7 ovf bank1", 64'(ovf), 2'b10);
    put(5, 32'h1234, 1, 1);
    put(1, 32'h1, 1, 1);
    put(1, 32'h1, 1, 1);
    quiet();
    chk("R7 bank0 clear", 64'(ovf), 2'b10);
    window = 1'b0;

    // R6 stop with window closed
    send_cmd(2'd3, '0); m_acq = 0;
    chk("R6 immediate stop", 64'(acq), 0);
    chk("R7 sticky after stop", 64'(ovf), 2'b10);
    for (int g = 0; g < NG; g++) read_chk(g, "R5 pattern readback");
    chk("R7 sticky after read", 64'(ovf), 2'b10);

    // R3 R7 new start clears flags and contents
    send_cmd(2'd0, '0);
    chk("R7 cleared", 64'(ovf), 0);
    send_cmd(2'd3, '0);
    for (int g = 0; g < NG; g++) exp_n[g] = 0;
    read_chk(5, "R3 cleared contents");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule